// File: doc/BRIEF.md
# Pipelined Instruction Fetch Stage

This block is the front stage of a five-stage, 32-bit load/store processor pipeline. It keeps a program counter that counts in whole words, reads one instruction word per cycle from a small on-block instruction memory, and forms the sequential next address by adding one. A one-bit branch-taken select, produced by a later stage, picks whether the counter next loads that sequential value or a 32-bit branch target. The fetched word and its sequential next address are captured into the fetch/decode pipeline register, which drives the stage outputs.

The memory is read combinationally from the current counter, so the word fetched in a cycle reaches the pipeline register at the end of that same cycle. The counter updates on every rising edge because the stage has no stall input. The memory contents come from a fixed fill rule computed at elaboration, so no file loading is needed. An active-low asynchronous reset clears the counter and both pipeline register fields to zero, so an all-zero word flows down the pipe after reset.

Top module: `ifetch_stage`

## Requirements
- R1: While `rst_n` is low, `fd_instr` and `fd_npc` are 0. The first fetch after reset reads address 0.
- R2: On each rising edge with `br_take` = 0, the program counter advances by exactly 1. Across consecutive sequential edges, `fd_npc` therefore rises by 1 per cycle.
- R3: The memory holds DEPTH = 128 words of 32 bits. Only the low 7 bits of the program counter index it, so counter values 128 and above wrap onto the same words. `fd_npc` keeps all 32 bits.
- R4: When `br_take` = 1 at an edge, the counter loads `br_target`. At the following edge, `fd_instr` = word(`br_target` mod 128) and `fd_npc` = `br_target` + 1.
- R5: While `br_take` = 0, the value on `br_target` has no effect on either output.
- R6: The incrementer wraps modulo 2^32. A counter value of 0xFFFFFFFF gives `fd_npc` = 0, and the next sequential fetch reads address 0.
- R7: Memory word a equals ((a * 0x9E3779B1) XOR 0x5A5A0000), truncated to 32 bits. Every registered pair satisfies `fd_instr` = word((`fd_npc` - 1) mod 128).
- R8: At the edge where a branch is taken, the pipeline register still captures the word at the current counter and that counter plus 1. The branch is seen at the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_take | input | 1 | 1 selects the branch target as the next counter value |
| br_target | input | 32 | Branch target as a word index |
| fd_instr | output | 32 | Registered fetched instruction |
| fd_npc | output | 32 | Registered sequential next address |

## Verification
A corrupted counter shows up at the ports one edge later. `fd_npc` breaks its step of one, or stops matching a taken target plus one, in the very next cycle. A wrong memory word or a wrong index slice shows up as a mismatched `fd_instr`/`fd_npc` pair at the next edge. A slice fault is visible once the counter passes 127 or a target with high bits set is taken. Sweeping the counter past the memory size, branching to every index plus high and all-ones targets, and resetting mid-run covers each of these within one or two cycles of the fault.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   // Source of the next program counter value
   typedef enum logic {
      NPC_SEQ    = 1'b0,
      NPC_BRANCH = 1'b1
   } npc_src_e;

   localparam logic [31:0] FILL_MUL = 32'h9E37_79B1;
   localparam logic [31:0] FILL_XOR = 32'h5A5A_0000;

   // Fixed fill rule for the instruction store
   function automatic logic [31:0] fill_word(input int unsigned idx);
      logic [31:0] prod;
      prod = idx * FILL_MUL;
      return prod ^ FILL_XOR;
   endfunction

endpackage

// File: rtl/ifetch_pc_unit.sv
module ifetch_pc_unit
   import ifetch_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_take,
   input  logic [XLEN-1:0] br_target,
   output logic [XLEN-1:0] pc_q,
   output logic [XLEN-1:0] pc_inc
);

   localparam logic [XLEN-1:0] STEP = XLEN'(1);

   npc_src_e        src;
   logic [XLEN-1:0] pc_d;

   initial begin
      assert (XLEN >= 8) else $error("ifetch_pc_unit: XLEN too small");
   end

   assign pc_inc = pc_q + STEP;
   assign src    = br_take ? NPC_BRANCH : NPC_SEQ;

   always_comb begin
      case (src)
         NPC_BRANCH: pc_d = br_target;
         default:    pc_d = pc_inc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   // R4: a taken branch loads the target
   p_branch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      br_take |=> pc_q == $past(br_target));

   // R2: no branch means a step of one (wrapping, R6)
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !br_take |=> pc_q == $past(pc_q) + STEP);

endmodule

// File: rtl/ifetch_rom.sv
module ifetch_rom
   import ifetch_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int DEPTH = 128,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [AW-1:0]   addr,
   output logic [XLEN-1:0] data
);

   logic [XLEN-1:0] words [DEPTH];

   initial begin
      assert (DEPTH == (1 << AW)) else $error("ifetch_rom: DEPTH must be a power of two");
      assert (XLEN >= 32) else $error("ifetch_rom: XLEN below fill width");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign words[g] = XLEN'(fill_word(g));
   end

   assign data = words[addr];

endmodule

// File: rtl/ifetch_fd_reg.sv
module ifetch_fd_reg #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] instr_d,
   input  logic [XLEN-1:0] npc_d,
   output logic [XLEN-1:0] instr_q,
   output logic [XLEN-1:0] npc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_q <= '0;
         npc_q   <= '0;
      end else begin
         instr_q <= instr_d;
         npc_q   <= npc_d;
      end
   end

endmodule

// File: rtl/ifetch_stage.sv
module ifetch_stage
   import ifetch_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int DEPTH = 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_take,
   input  logic [XLEN-1:0] br_target,
   output logic [XLEN-1:0] fd_instr,
   output logic [XLEN-1:0] fd_npc
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [XLEN-1:0] ONE = XLEN'(1);

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_inc;
   logic [XLEN-1:0] rom_data;
   logic            primed_q;

   initial begin
      assert (AW <= XLEN) else $error("ifetch_stage: memory wider than counter");
   end

   ifetch_pc_unit #(.XLEN(XLEN)) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_take   (br_take),
      .br_target (br_target),
      .pc_q      (pc_q),
      .pc_inc    (pc_inc)
   );

   ifetch_rom #(.XLEN(XLEN), .DEPTH(DEPTH)) u_rom (
      .addr (pc_q[AW-1:0]),
      .data (rom_data)
   );

   ifetch_fd_reg #(.XLEN(XLEN)) u_fd (
      .clk     (clk),
      .rst_n   (rst_n),
      .instr_d (rom_data),
      .npc_d   (pc_inc),
      .instr_q (fd_instr),
      .npc_q   (fd_npc)
   );

   // Marks that the pipeline register has been loaded since reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   // R1: outputs still clear at the first edge after reset release
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fd_instr == '0 && fd_npc == '0));

   // R7: every registered pair is consistent with the fill rule
   p_pair_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> fd_instr == XLEN'(fill_word(int'((fd_npc - ONE) & XLEN'(DEPTH - 1)))));

   // R4, R8: a taken branch reaches the outputs two edges later
   p_branch_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      br_take |=> ##1 (fd_npc == $past(br_target, 2) + ONE));

   // R2: sequential fetch advances the registered next address by one
   p_seq_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !br_take |=> ##1 (fd_npc == $past(fd_npc) + ONE));

endmodule

// File: tb/tb_ifetch_stage.sv
module tb_ifetch_stage;

   localparam int  XLEN = 32;
   localparam int  DEPTH = 128;
   localparam time TCK = 20ns;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            br_take = 1'b0;
   logic [XLEN-1:0] br_target = '0;
   logic [XLEN-1:0] fd_instr;
   logic [XLEN-1:0] fd_npc;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] exp_pc;

   ifetch_stage #(.XLEN(XLEN), .DEPTH(DEPTH)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_take   (br_take),
      .br_target (br_target),
      .fd_instr  (fd_instr),
      .fd_npc    (fd_npc)
   );

   always #(TCK/2) clk = ~clk;

   // Word rule taken from R7
   function automatic logic [31:0] word_of(input logic [31:0] a);
      logic [31:0] idx;
      idx = a % 32'd128;
      return (idx * 32'h9E37_79B1) ^ 32'h5A5A_0000;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, take one rising edge, compare at the next falling edge
   task automatic step(input logic sel, input logic [31:0] tgt, input string req);
      logic [31:0] e_instr;
      logic [31:0] e_npc;
      br_take   = sel;
      br_target = tgt;
      @(posedge clk);
      e_instr = word_of(exp_pc);
      e_npc   = exp_pc + 32'd1;
      exp_pc  = sel ? tgt : exp_pc + 32'd1;
      @(negedge clk);
      check({req, " instr"}, fd_instr, e_instr);
      check({req, " npc"}, fd_npc, e_npc);
   endtask

   initial begin
      #(TCK * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      exp_pc = '0;
      // R1: reset holds outputs at zero
      repeat (3) @(negedge clk);
      check("R1 reset instr", fd_instr, 32'h0);
      check("R1 reset npc", fd_npc, 32'h0);
      rst_n = 1'b1;

      // R2 R3 R5: long sequential run past the memory size with a moving unused target
      for (int k = 0; k < 300; k++) begin
         step(1'b0, 32'hDEAD_0000 ^ (k * 32'h0101_0107), "R2/R3/R5 seq");
      end

      // R4 R8: branch to every index, each followed by a sequential step
      for (int t = 0; t < DEPTH; t++) begin
         step(1'b1, (t * 32'd7) % 32'd128, "R8 branch edge");
         step(1'b0, 32'hFFFF_FFFF, "R4 after branch");
      end

      // R3 R4: targets with high bits set use only the low index bits
      step(1'b1, 32'h0001_0085, "R8 branch edge hi");
      step(1'b0, 32'h0, "R3 hi target");
      step(1'b0, 32'h0, "R3 hi target seq");
      step(1'b1, 32'h8000_007F, "R8 branch edge top");
      step(1'b0, 32'h0, "R4 top target");

      // Back-to-back taken branches
      step(1'b1, 32'd10, "R4 b2b first");
      step(1'b1, 32'd200, "R4 b2b second");
      step(1'b0, 32'd0, "R4 b2b land");

      // R6: counter at all ones wraps to zero
      step(1'b1, 32'hFFFF_FFFF, "R6 load max");
      step(1'b0, 32'h1234_5678, "R6 max fetch");
      step(1'b0, 32'h1234_5678, "R6 wrapped fetch");
      step(1'b0, 32'h0, "R6 after wrap");

      // R1: reset in the middle of a run clears at once and restarts at address 0
      @(negedge clk);
      exp_pc = exp_pc + 32'd1;
      br_take = 1'b0;
      #(TCK/4);
      rst_n = 1'b0;
      #(TCK/8);
      check("R1 midrun instr", fd_instr, 32'h0);
      check("R1 midrun npc", fd_npc, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_pc = '0;
      step(1'b0, 32'h0, "R1 restart");
      step(1'b0, 32'h0, "R1 restart seq");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule